// File: doc/BRIEF.md
# SD Card Single-Block Read Engine

This engine fetches one 512-byte logical block from an already initialized high-capacity SD card running in SPI mode. A host supplies a 32-bit block number and pulses `start`. The engine then drives a byte-level SPI exchange port, which is served by a separate bit shifter. Each byte exchange is full duplex: the engine presents a byte on `spiTx` together with a one-cycle `spiStart`, and the shifter answers later with a one-cycle `spiDone` carrying the byte that came back on `spiRx`.

The engine sends the six-byte read command. It skips filler bytes until the one-byte command response arrives and, if that response is clean, hunts for the data start token. It forwards the 512 payload bytes in order on a valid/byte/index interface and clocks in the two trailing CRC bytes without checking them. It then releases chip select and sends one more filler byte. Completion is a one-cycle `done` pulse. An error kind and an error detail byte are held from that point until the next start. Every byte the engine sends other than the command frame is 0xFF.

Top module: `sd_block_reader`

## Requirements
- R1: After `start` in idle, the first six bytes sent are 0x51, `blockNum[31:24]`, `blockNum[23:16]`, `blockNum[15:8]`, `blockNum[7:0]`, 0xFF, each with `csN` low. The block number is latched at `start`.
- R2: Every byte sent after the command frame is 0xFF. While the response is awaited, received bytes with bit 7 set are skipped. If RESP_LIMIT (default 8) such bytes arrive, the read ends with `errKind` = 1 and `errDetail` = 0.
- R3: A response byte with bit 7 clear is the command response. A non-zero value ends the read with `errKind` = 2 and `errDetail` equal to that byte.
- R4: After a zero response, bytes are exchanged until 0xFE arrives. If TOKEN_LIMIT (default 65535) bytes arrive without it, the read ends with `errKind` = 3 and `errDetail` = 0.
- R5: During the token hunt, a received byte whose upper four bits are zero ends the read with `errKind` = 4 and `errDetail` = {4'h0, low nibble of that byte}.
- R6: The 512 bytes that follow the start token appear on `dataByte` in arrival order. Each is shown for exactly one cycle with `dataValid` high and `dataIndex` counting 0 to 511.
- R7: Exactly two bytes are exchanged after the last payload byte with `csN` low. They never appear on the data output.
- R8: When a read ends, whether it succeeded or failed, exactly one more 0xFF byte is exchanged with `csN` high. `done` is then high for one cycle with `busy` low. `errKind` is 0 on success. `errKind` and `errDetail` stay stable until the next `start`.
- R9: `start` while `busy` is high has no effect on the bytes sent, the data output or the result.
- R10: During and after reset, `busy`, `done`, `dataValid` and `spiStart` are low, `csN` is high and `errKind` is 0. An exchange the shifter completes for a read that reset aborted is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a read (ignored while busy) |
| blockNum | input | 32 | Logical 512-byte block number |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle completion pulse |
| errKind | output | 3 | 0 ok, 1 response timeout, 2 bad response, 3 token timeout, 4 data error token |
| errDetail | output | 8 | Response byte (kind 2), token nibble (kind 4), else 0 |
| spiStart | output | 1 | Begin one byte exchange |
| spiTx | output | 8 | Byte to send, valid with spiStart |
| csN | output | 1 | Card chip select, active low |
| spiDone | input | 1 | Exchange finished pulse |
| spiRx | input | 8 | Received byte, valid with spiDone |
| dataValid | output | 1 | Payload byte valid |
| dataByte | output | 8 | Payload byte |
| dataIndex | output | $clog2(BLOCK_BYTES) | Position of the payload byte in the block |

## Verification
A wrong phase state or a miscounted byte counter shows up at the SPI port within one byte exchange: a stray command byte, a filler where a command byte belongs, or `csN` rising too early or too late. A counter that is off by one shows up at the end of the read, as a total byte count that is wrong by one or a payload index that does not reach 511. A misclassified response or token shows up in the error kind and detail held after `done`. It also shows up one exchange later as a missing or extra payload.

// File: rtl/sd_rd_pkg.sv
package sd_rd_pkg;

  localparam logic [7:0] CMD_READ_ONE = 8'h51;
  localparam logic [7:0] FILL_BYTE    = 8'hFF;
  localparam logic [7:0] START_TOKEN  = 8'hFE;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_RESP, ST_TOKEN, ST_DATA, ST_CRC, ST_TAIL
  } rdStateT;

  typedef enum logic [2:0] {
    ERR_NONE          = 3'd0,
    ERR_RESP_TIMEOUT  = 3'd1,
    ERR_BAD_RESPONSE  = 3'd2,
    ERR_TOKEN_TIMEOUT = 3'd3,
    ERR_DATA_TOKEN    = 3'd4
  } errKindT;

  typedef struct packed {
    logic    loadCmd;
    logic    shiftCmd;
    logic    sendCmd;
    logic    clrCnt;
    logic    incCnt;
    logic    emitByte;
    logic    setErr;
    logic    errRaw;
    logic    errNibble;
    errKindT errKind;
    logic    finish;
  } ctrlStrobeT;

endpackage

// File: rtl/sd_rd_datapath.sv
module sd_rd_datapath
  import sd_rd_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int CNT_W       = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  ctrlStrobeT                     ctrl,
  input  logic [31:0]                    blockNum,
  input  logic [7:0]                     spiRx,
  output logic [7:0]                     txByte,
  output logic [CNT_W-1:0]               cnt,
  output logic                           dataValid,
  output logic [7:0]                     dataByte,
  output logic [$clog2(BLOCK_BYTES)-1:0] dataIndex,
  output logic                           done,
  output errKindT                        errKind,
  output logic [7:0]                     errDetail
);

  localparam int IDX_W     = $clog2(BLOCK_BYTES);
  localparam int FRAME_W   = 48;

  logic [FRAME_W-1:0] cmdReg;

  assign txByte = ctrl.sendCmd ? cmdReg[FRAME_W-1 -: 8] : FILL_BYTE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdReg <= '1;
    end else if (ctrl.loadCmd) begin
      cmdReg <= {CMD_READ_ONE, blockNum, FILL_BYTE};
    end else if (ctrl.shiftCmd) begin
      cmdReg <= {cmdReg[FRAME_W-9:0], FILL_BYTE};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (ctrl.clrCnt)  cnt <= '0;
    else if (ctrl.incCnt)  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataValid <= 1'b0;
      dataByte  <= '0;
      dataIndex <= '0;
      done      <= 1'b0;
    end else begin
      dataValid <= ctrl.emitByte;
      done      <= ctrl.finish;
      if (ctrl.emitByte) begin
        dataByte  <= spiRx;
        dataIndex <= cnt[IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      errKind   <= ERR_NONE;
      errDetail <= '0;
    end else if (ctrl.loadCmd) begin
      errKind   <= ERR_NONE;
      errDetail <= '0;
    end else if (ctrl.setErr) begin
      errKind   <= ctrl.errKind;
      if (ctrl.errRaw)         errDetail <= spiRx;
      else if (ctrl.errNibble) errDetail <= {4'h0, spiRx[3:0]};
      else                     errDetail <= '0;
    end
  end

endmodule

// File: rtl/sd_rd_control.sv
module sd_rd_control
  import sd_rd_pkg::*;
#(
  parameter int RESP_LIMIT  = 8,
  parameter int TOKEN_LIMIT = 65535,
  parameter int BLOCK_BYTES = 512,
  parameter int CMD_BYTES   = 6,
  parameter int CRC_BYTES   = 2,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             spiDone,
  input  logic [7:0]       spiRx,
  input  logic [CNT_W-1:0] cnt,
  output ctrlStrobeT       ctrl,
  output logic             spiStart,
  output logic             csN,
  output logic             busy
);

  localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_BYTES - 1);
  localparam logic [CNT_W-1:0] LAST_RESP = CNT_W'(RESP_LIMIT - 1);
  localparam logic [CNT_W-1:0] LAST_TOK  = CNT_W'(TOKEN_LIMIT - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BLOCK_BYTES - 1);
  localparam logic [CNT_W-1:0] LAST_CRC  = CNT_W'(CRC_BYTES - 1);

  rdStateT state, nextState;
  logic    pending;
  logic    xferDone;

  assign busy     = (state != ST_IDLE);
  assign spiStart = busy && !pending;
  assign xferDone = pending && spiDone;
  assign csN      = (state == ST_IDLE) || (state == ST_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
    end else begin
      state <= nextState;
      if (spiStart)      pending <= 1'b1;
      else if (xferDone) pending <= 1'b0;
    end
  end

  always_comb begin
    ctrl         = '0;
    ctrl.sendCmd = (state == ST_CMD);
    nextState    = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          ctrl.loadCmd = 1'b1;
          ctrl.clrCnt  = 1'b1;
          nextState    = ST_CMD;
        end
      end
      ST_CMD: begin
        if (xferDone) begin
          ctrl.shiftCmd = 1'b1;
          if (cnt == LAST_CMD) begin
            ctrl.clrCnt = 1'b1;
            nextState   = ST_RESP;
          end else begin
            ctrl.incCnt = 1'b1;
          end
        end
      end
      ST_RESP: begin
        if (xferDone) begin
          if (!spiRx[7]) begin
            if (spiRx == 8'h00) begin
              ctrl.clrCnt = 1'b1;
              nextState   = ST_TOKEN;
            end else begin
              ctrl.setErr  = 1'b1;
              ctrl.errRaw  = 1'b1;
              ctrl.errKind = ERR_BAD_RESPONSE;
              nextState    = ST_TAIL;
            end
          end else if (cnt == LAST_RESP) begin
            ctrl.setErr  = 1'b1;
            ctrl.errKind = ERR_RESP_TIMEOUT;
            nextState    = ST_TAIL;
          end else begin
            ctrl.incCnt = 1'b1;
          end
        end
      end
      ST_TOKEN: begin
        if (xferDone) begin
          if (spiRx == START_TOKEN) begin
            ctrl.clrCnt = 1'b1;
            nextState   = ST_DATA;
          end else if (spiRx[7:4] == 4'h0) begin
            ctrl.setErr    = 1'b1;
            ctrl.errNibble = 1'b1;
            ctrl.errKind   = ERR_DATA_TOKEN;
            nextState      = ST_TAIL;
          end else if (cnt == LAST_TOK) begin
            ctrl.setErr  = 1'b1;
            ctrl.errKind = ERR_TOKEN_TIMEOUT;
            nextState    = ST_TAIL;
          end else begin
            ctrl.incCnt = 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (xferDone) begin
          ctrl.emitByte = 1'b1;
          if (cnt == LAST_DATA) begin
            ctrl.clrCnt = 1'b1;
            nextState   = ST_CRC;
          end else begin
            ctrl.incCnt = 1'b1;
          end
        end
      end
      ST_CRC: begin
        if (xferDone) begin
          if (cnt == LAST_CRC) nextState   = ST_TAIL;
          else                 ctrl.incCnt = 1'b1;
        end
      end
      ST_TAIL: begin
        if (xferDone) begin
          ctrl.finish = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R1, R9: a byte exchange is only ever launched while a read is active
  p_launch_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    spiStart |-> (state != ST_IDLE));

  // R8: a setErr strobe is followed by the chip-select release phase
  p_err_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.setErr |=> csN && busy);

endmodule

// File: rtl/sd_block_reader.sv
module sd_block_reader
  import sd_rd_pkg::*;
#(
  parameter int RESP_LIMIT  = 8,
  parameter int TOKEN_LIMIT = 65535,
  parameter int BLOCK_BYTES = 512
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [31:0]                    blockNum,
  output logic                           busy,
  output logic                           done,
  output logic [2:0]                     errKind,
  output logic [7:0]                     errDetail,
  output logic                           spiStart,
  output logic [7:0]                     spiTx,
  output logic                           csN,
  input  logic                           spiDone,
  input  logic [7:0]                     spiRx,
  output logic                           dataValid,
  output logic [7:0]                     dataByte,
  output logic [$clog2(BLOCK_BYTES)-1:0] dataIndex
);

  localparam int MAX_COUNT = (TOKEN_LIMIT > BLOCK_BYTES) ? TOKEN_LIMIT : BLOCK_BYTES;
  localparam int CNT_W     = $clog2(MAX_COUNT + 1);

  ctrlStrobeT        ctrl;
  logic [CNT_W-1:0]  cnt;
  errKindT           errKindInt;

  sd_rd_control #(
    .RESP_LIMIT (RESP_LIMIT),
    .TOKEN_LIMIT(TOKEN_LIMIT),
    .BLOCK_BYTES(BLOCK_BYTES),
    .CMD_BYTES  (6),
    .CRC_BYTES  (2),
    .CNT_W      (CNT_W)
  ) i_control (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .spiDone (spiDone),
    .spiRx   (spiRx),
    .cnt     (cnt),
    .ctrl    (ctrl),
    .spiStart(spiStart),
    .csN     (csN),
    .busy    (busy)
  );

  sd_rd_datapath #(
    .BLOCK_BYTES(BLOCK_BYTES),
    .CNT_W      (CNT_W)
  ) i_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .blockNum (blockNum),
    .spiRx    (spiRx),
    .txByte   (spiTx),
    .cnt      (cnt),
    .dataValid(dataValid),
    .dataByte (dataByte),
    .dataIndex(dataIndex),
    .done     (done),
    .errKind  (errKindInt),
    .errDetail(errDetail)
  );

  assign errKind = errKindInt;

  // R6: payload bytes only appear while the card is still selected
  p_valid_selected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dataValid |-> !csN);

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: completion only with the card released and the engine idle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> csN && !busy);

  // R8: result is held while idle and no new read begins
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(errKind) && $stable(errDetail));

  // R3: a bad response detail is a non-zero byte with bit 7 clear
  p_resp_detail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (errKind == 3'd2) |-> (errDetail != 8'h00) && !errDetail[7]);

  // R5: a data error token detail carries only a nibble
  p_token_nibble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (errKind == 3'd4) |-> (errDetail[7:4] == 4'h0));

endmodule

// File: tb/test_sd_block_reader.sv
`timescale 1ns/1ps
module test_sd_block_reader;

  localparam int RESP_LIM = 8;
  localparam int TOK_LIM  = 40;
  localparam int NBYTES   = 512;

  typedef struct packed {
    logic [31:0] blk;
    logic [7:0]  rd;
    logic [7:0]  r1;
    logic [7:0]  td;
    logic [7:0]  tok;
    logic [2:0]  kind;
    logic [7:0]  det;
  } vecT;

  localparam int NVEC = 8;
  localparam vecT VECS [NVEC] = '{
    '{32'h0000_0000, 8'd0, 8'h00, 8'd0,  8'hFE, 3'd0, 8'h00},
    '{32'h1234_5678, 8'd3, 8'h00, 8'd5,  8'hFE, 3'd0, 8'h00},
    '{32'hFFFF_FFFF, 8'd7, 8'h00, 8'd39, 8'hFE, 3'd0, 8'h00},
    '{32'h0000_00A5, 8'd1, 8'h05, 8'd0,  8'hFE, 3'd2, 8'h05},
    '{32'h0000_0001, 8'd8, 8'h00, 8'd0,  8'hFE, 3'd1, 8'h00},
    '{32'h0000_0002, 8'd0, 8'h00, 8'd40, 8'hFE, 3'd3, 8'h00},
    '{32'h0000_0003, 8'd2, 8'h00, 8'd4,  8'h09, 3'd4, 8'h09},
    '{32'h8000_0000, 8'd0, 8'h01, 8'd0,  8'hFE, 3'd2, 8'h01}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] blockNum = '0;
  logic        busy, done, spiStart, csN, dataValid;
  logic [2:0]  errKind;
  logic [7:0]  errDetail, spiTx, dataByte;
  logic [8:0]  dataIndex;
  logic        spiDone = 1'b0;
  logic [7:0]  spiRx = 8'hFF;

  always #5 clk = ~clk;

  sd_block_reader #(
    .RESP_LIMIT (RESP_LIM),
    .TOKEN_LIMIT(TOK_LIM),
    .BLOCK_BYTES(NBYTES)
  ) i_sd_block_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .blockNum(blockNum),
    .busy(busy), .done(done), .errKind(errKind), .errDetail(errDetail),
    .spiStart(spiStart), .spiTx(spiTx), .csN(csN),
    .spiDone(spiDone), .spiRx(spiRx),
    .dataValid(dataValid), .dataByte(dataByte), .dataIndex(dataIndex)
  );

  int nChecks = 0;
  int nFails  = 0;

  logic [31:0] sBlk = '0;
  int          sRd = 0, sTd = 0;
  logic [7:0]  sR1 = 8'h00, sTok = 8'hFE;
  int          byteIdx = 0, expTotal = 0, txErr = 0, dataCount = 0, dataErr = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input logic [31:0] b);
    return 8'((i * 13) + (i >> 8)) ^ b[7:0];
  endfunction

  function automatic logic [7:0] txExp(input int idx);
    case (idx)
      0: return 8'h51;
      1: return sBlk[31:24];
      2: return sBlk[23:16];
      3: return sBlk[15:8];
      4: return sBlk[7:0];
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] rxAt(input int idx);
    int p;
    p = idx;
    if (p < 6) return 8'hFF;
    p = p - 6;
    if (p < sRd) return 8'hFF;
    if (p == sRd) return sR1;
    p = p - sRd - 1;
    if (sR1 != 8'h00) return 8'hFF;
    if (p < sTd) return 8'hFF;
    if (p == sTd) return sTok;
    p = p - sTd - 1;
    if (sTok != 8'hFE) return 8'hFF;
    if (p < NBYTES) return pat(p, sBlk);
    if (p == NBYTES) return 8'h12;
    if (p == NBYTES + 1) return 8'h34;
    return 8'hFF;
  endfunction

  // Card model on the byte-exchange port
  initial begin
    logic [7:0] r;
    forever begin
      @(negedge clk);
      spiDone = 1'b0;
      if (spiStart) begin
        if (spiTx !== txExp(byteIdx)) txErr++;
        if (byteIdx < expTotal - 1) begin
          if (csN !== 1'b0) txErr++;
        end else begin
          if (csN !== 1'b1) txErr++;
        end
        r = rxAt(byteIdx);
        byteIdx++;
        repeat (2) @(negedge clk);
        spiDone = 1'b1;
        spiRx   = r;
      end
    end
  end

  // Payload monitor
  initial begin
    forever begin
      @(negedge clk);
      if (dataValid) begin
        if (dataIndex !== dataCount[8:0] || dataByte !== pat(dataCount, sBlk)) dataErr++;
        dataCount++;
      end
    end
  end

  task automatic runVec(input vecT v, input int pokeAt);
    int cyc;
    int respPh, tokPh;
    bit r1Ok, allOk;
    sBlk = v.blk; sRd = int'(v.rd); sR1 = v.r1; sTd = int'(v.td); sTok = v.tok;
    byteIdx = 0; txErr = 0; dataCount = 0; dataErr = 0;
    respPh = (sRd >= RESP_LIM) ? RESP_LIM : sRd + 1;
    r1Ok   = (sRd < RESP_LIM) && (sR1 == 8'h00);
    tokPh  = (sTd >= TOK_LIM) ? TOK_LIM : sTd + 1;
    allOk  = r1Ok && (sTd < TOK_LIM) && (sTok == 8'hFE);
    expTotal = 6 + respPh + (r1Ok ? tokPh + (allOk ? NBYTES + 2 : 0) : 0) + 1;
    @(negedge clk);
    blockNum = v.blk;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (cyc == pokeAt) begin
        start = 1'b1; blockNum = ~v.blk;
      end else if (cyc == pokeAt + 1) begin
        start = 1'b0; blockNum = v.blk;
      end
    end
    check(cyc < 20000, "R8", "read completes", cyc, 20000);
    check(errKind === v.kind, "R2/R3/R4/R5", "errKind", errKind, v.kind);
    check(errDetail === v.det, "R3/R5", "errDetail", errDetail, v.det);
    check(byteIdx == expTotal, "R7/R8", "bytes exchanged", byteIdx, expTotal);
    check(txErr == 0, "R1/R2", "tx byte or chip-select mismatches", txErr, 0);
    check(dataCount == (allOk ? NBYTES : 0), "R6", "payload bytes", dataCount,
          allOk ? NBYTES : 0);
    check(dataErr == 0, "R6", "payload order or value mismatches", dataErr, 0);
    check(!busy && csN, "R8", "idle and released at done", {busy, csN}, 2'b01);
    @(negedge clk);
    check(!done, "R8", "done is one cycle", done, 0);
  endtask

  initial begin
    #2000000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check(!busy && !done && !dataValid && !spiStart, "R10", "outputs low in reset",
          {busy, done, dataValid, spiStart}, 0);
    check(csN === 1'b1, "R10", "csN high in reset", csN, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(errKind === 3'd0 && !busy, "R10", "idle after reset", {errKind, busy}, 0);

    // Vector table: R1..R8
    for (int i = 0; i < NVEC; i++) runVec(VECS[i], 0);

    // R9: start while busy is ignored
    runVec(VECS[1], 50);

    // R10: reset in the middle of a read, then a clean read
    sBlk = 32'h0BAD_F00D; sRd = 0; sR1 = 8'h00; sTd = 0; sTok = 8'hFE;
    byteIdx = 0; expTotal = 1000;
    @(negedge clk);
    blockNum = sBlk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(csN === 1'b1 && !busy && !spiStart && !dataValid, "R10",
          "abort by reset", {csN, busy, spiStart, dataValid}, 4'b1000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(!busy && !spiStart && errKind === 3'd0, "R10", "stray exchange ignored",
          {busy, spiStart, errKind}, 0);
    runVec(VECS[0], 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule